// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block decides when an external converter samples and which input it samples. A start event can come from a software strobe, from an internal pacing timer, or from an external trigger line. Each start event leads to one conversion or to a whole burst of conversions. For each conversion the block raises a one-cycle request with a 3-bit channel number and that channel's 4-bit gain code. It then waits for the converter's done strobe, attaches the channel number to the returned sample, and offers the tagged word to a downstream FIFO.

Configuration is loaded as one group with a write strobe. The group holds a two-bit sequencing mode, the index of the last channel (so up to eight channels), a packed gain word, a pacing divisor, a burst-enable bit and a bit that selects the external trigger as the start source. Every configuration write, and every soft-reset strobe, returns the sequencer to idle. Two sticky flags report problems: a start event that arrived while the sequencer was busy, and a sample that was lost because the FIFO was full. Each flag is cleared by writing a 1 to its clear input.

Top module: `adc_scan_seq`

## Requirements
- R1: With the effective burst mode off, each start event produces exactly one request. No further request follows until the next start event.
- R2: With the effective burst mode on, one start event produces requests for channels 0, 1, … up to `cfg_last` in that order. The sequencer then stays idle until a new start event.
- R3: The burst bit is treated as 0 when `cfg_mode` is 2'b00 or `cfg_last` is 0.
- R4: Inside a burst with a nonzero divisor D, each later request waits for a pacing tick, so consecutive requests are spaced D cycles apart. With D = 0, the next request is raised in the cycle right after the done strobe is sampled.
- R5: `conv_gain` equals bits [4n+3:4n] of `cfg_gain`, where n is the channel in `conv_ch`.
- R6: With D = 0, only `sw_start` starts conversions, and `ext_trig` has no effect. With D ≠ 0 and `cfg_ext_en` = 0, a pacing tick every D cycles starts conversions while the sequencer is idle. With D ≠ 0 and `cfg_ext_en` = 1, `ext_trig` starts them.
- R7: In single mode with `cfg_mode` ≠ 0, the channel advances by one after each conversion and wraps to 0 after `cfg_last`. With `cfg_mode` = 0, every conversion uses channel 0.
- R8: A `sw_start` (or an enabled `ext_trig`) that arrives while a conversion or burst is in progress starts nothing and sets `ovr_flag`. `ovr_flag` stays set until a cycle with `ovr_clr` = 1.
- R9: One cycle after a sampled `adc_done`, `fifo_push` pulses with `fifo_data` = {channel[18:16], sample[15:0]}. If `fifo_full` is 1 at the done cycle, no push happens and `ovf_flag` is set until `ovf_clr`.
- R10: `cfg_we` or `soft_rst` returns the sequencer to idle with channel 0 and restarts the pacing count. The first periodic request then comes exactly D cycles after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads the configuration group and clears the sequencer |
| cfg_mode | input | 2 | Sequencing mode; 00 means no sequencing |
| cfg_last | input | 3 | Index of the last channel |
| cfg_gain | input | 32 | One 4-bit gain code per channel |
| cfg_div | input | 16 | Pacing divisor; 0 selects software-only starts |
| cfg_scan | input | 1 | Burst enable |
| cfg_ext_en | input | 1 | Selects the external trigger as the start source when timed |
| soft_rst | input | 1 | Clears the sequencer and keeps the configuration |
| sw_start | input | 1 | Software start strobe |
| ext_trig | input | 1 | External trigger strobe |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | 3 | Channel for the request |
| conv_gain | output | 4 | Gain code for the request |
| adc_done | input | 1 | Converter done strobe |
| adc_data | input | 16 | Converter sample |
| fifo_full | input | 1 | Downstream full indication |
| fifo_push | output | 1 | Push strobe toward the FIFO |
| fifo_data | output | 19 | Channel tag and sample |
| ovr_flag | output | 1 | Sticky overrun flag (start while busy) |
| ovf_flag | output | 1 | Sticky overflow flag (push while full) |

## Verification
The embedded properties check, on every cycle, the local rules:
- a burst begins at channel 0;
- a single conversion returns the sequencer to idle;
- a busy start sets the overrun flag;
- a full FIFO blocks the push and sets the overflow flag;
- a clear strobe sends the sequencer home;
- pacing ticks come back to back only with a divisor of 1.

Only the directed scenarios can show the behaviour that spans a whole sequence:
- the full channel order of a burst and the wrap of the single-mode pointer;
- the measured request spacing for a given divisor;
- the suppression of external triggers in software mode;
- the exact latency from a configuration write to the first timed request.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int NUM_CH  = 8;
    localparam int CH_W    = $clog2(NUM_CH);
    localparam int GAIN_W  = 4;
    localparam int DIV_W   = 16;
    localparam int DATA_W  = 16;
    localparam int TAGGED_W = CH_W + DATA_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_GAP  = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic [1:0]                 mode;
        logic [CH_W-1:0]            last;
        logic [NUM_CH*GAIN_W-1:0]   gain;
        logic [DIV_W-1:0]           div;
        logic                       scan;
        logic                       ext_en;
    } seq_cfg_t;
endpackage

// File: rtl/adc_seq_pacer.sv
module adc_seq_pacer
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (div != '0) && (cnt_q == div - 1'b1);
        cnt_d = cnt_q + 1'b1;
        if (clr || tick || (div == '0)) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4: ticks are D cycles apart, so two in a row only when D is 1
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && div > 1) |=> !tick);
    // R10: a clear restarts the count from zero
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (div <= 1 || !tick));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  seq_cfg_t          cfg,
    input  logic              tick,
    input  logic              sw_start,
    input  logic              ext_trig,
    input  logic              adc_done,
    input  logic              ovr_clr,
    output logic              req_o,
    output logic [CH_W-1:0]   ch_o,
    output logic [GAIN_W-1:0] gain_o,
    output logic              res_valid_o,
    output logic [CH_W-1:0]   res_ch_o,
    output logic              ovr_o
);
    typedef struct packed {
        seq_st_e           st;
        logic [CH_W-1:0]   ptr;
        logic              req;
        logic [GAIN_W-1:0] gain;
        logic              ovr;
    } ctrl_t;

    ctrl_t q, d;
    logic timed, seq_en, scan_eff, idle_start, busy_start, at_last;
    logic [CH_W-1:0] ptr_inc;

    always_comb begin
        timed      = (cfg.div != '0);
        seq_en     = (cfg.mode != 2'b00);
        scan_eff   = cfg.scan && seq_en && (cfg.last != '0);
        idle_start = sw_start || (timed && (cfg.ext_en ? ext_trig : tick));
        busy_start = sw_start || (timed && cfg.ext_en && ext_trig);
        at_last    = (q.ptr == cfg.last);
        ptr_inc    = at_last ? '0 : q.ptr + 1'b1;

        d           = q;
        d.req       = 1'b0;
        res_valid_o = 1'b0;
        if (ovr_clr) d.ovr = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (idle_start) begin
                    d.st  = ST_CONV;
                    d.req = 1'b1;
                end
            end
            ST_CONV: begin
                if (busy_start) d.ovr = 1'b1;
                if (adc_done) begin
                    res_valid_o = 1'b1;
                    if (scan_eff) begin
                        if (at_last) begin
                            d.ptr = '0;
                            d.st  = ST_IDLE;
                        end else begin
                            d.ptr = q.ptr + 1'b1;
                            if (timed) begin
                                d.st = ST_GAP;
                            end else begin
                                d.st  = ST_CONV;
                                d.req = 1'b1;
                            end
                        end
                    end else begin
                        d.ptr = seq_en ? ptr_inc : '0;
                        d.st  = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                if (busy_start) d.ovr = 1'b1;
                if (tick) begin
                    d.st  = ST_CONV;
                    d.req = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (clr) begin
            d.st        = ST_IDLE;
            d.ptr       = '0;
            d.req       = 1'b0;
            res_valid_o = 1'b0;
        end
        d.gain = cfg.gain[d.ptr*GAIN_W +: GAIN_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, ptr: '0, req: 1'b0, gain: '0, ovr: 1'b0};
        else        q <= d;
    end

    assign req_o    = q.req;
    assign ch_o     = q.ptr;
    assign gain_o   = q.gain;
    assign res_ch_o = q.ptr;
    assign ovr_o    = q.ovr;

    // R2: a burst always opens on channel 0
    p_burst_ch0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && idle_start && scan_eff && !clr) |=> (req_o && ch_o == '0));
    // R2: no request names a channel beyond the last index
    p_ch_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (ch_o <= cfg.last));
    // R1: a finished single conversion leaves the sequencer idle
    p_single_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_CONV && adc_done && !scan_eff && !clr) |=> (q.st == ST_IDLE && !req_o));
    // R8: a start while busy raises the sticky overrun flag
    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && busy_start) |=> ovr_o);
    // R10: a clear sends the sequencer home
    p_home_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.st == ST_IDLE && ch_o == '0 && !req_o));
endmodule

// File: rtl/adc_seq_pusher.sv
module adc_seq_pusher
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                res_valid,
    input  logic [CH_W-1:0]     res_ch,
    input  logic [DATA_W-1:0]   res_data,
    input  logic                fifo_full,
    input  logic                ovf_clr,
    output logic                push_o,
    output logic [TAGGED_W-1:0] data_o,
    output logic                ovf_o
);
    typedef struct packed {
        logic                push;
        logic [TAGGED_W-1:0] data;
        logic                ovf;
    } push_t;

    push_t q, d;

    always_comb begin
        d      = q;
        d.push = res_valid && !fifo_full;
        if (res_valid) d.data = {res_ch, res_data};
        if (ovf_clr) d.ovf = 1'b0;
        if (res_valid && fifo_full) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign push_o = q.push;
    assign data_o = q.data;
    assign ovf_o  = q.ovf;

    // R9: a full FIFO blocks the push and flags the loss
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && fifo_full) |=> (!push_o && ovf_o));
    // R9: an accepted result carries its channel tag
    p_push_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !fifo_full) |=> (push_o && data_o[TAGGED_W-1 -: CH_W] == $past(res_ch)));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_seq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_mode,
    input  logic [CH_W-1:0]           cfg_last,
    input  logic [NUM_CH*GAIN_W-1:0]  cfg_gain,
    input  logic [DIV_W-1:0]          cfg_div,
    input  logic                      cfg_scan,
    input  logic                      cfg_ext_en,
    input  logic                      soft_rst,
    input  logic                      sw_start,
    input  logic                      ext_trig,
    input  logic                      ovr_clr,
    input  logic                      ovf_clr,
    output logic                      conv_req,
    output logic [CH_W-1:0]           conv_ch,
    output logic [GAIN_W-1:0]         conv_gain,
    input  logic                      adc_done,
    input  logic [DATA_W-1:0]         adc_data,
    input  logic                      fifo_full,
    output logic                      fifo_push,
    output logic [TAGGED_W-1:0]       fifo_data,
    output logic                      ovr_flag,
    output logic                      ovf_flag
);
    seq_cfg_t        cfg_d, cfg_q;
    logic            clr, tick, res_valid;
    logic [CH_W-1:0] res_ch;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            cfg_d = '{mode: cfg_mode, last: cfg_last, gain: cfg_gain,
                      div: cfg_div, scan: cfg_scan, ext_en: cfg_ext_en};
        end
        clr = cfg_we || soft_rst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    adc_seq_pacer u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .div   (cfg_q.div),
        .tick  (tick)
    );

    adc_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .cfg         (cfg_q),
        .tick        (tick),
        .sw_start    (sw_start),
        .ext_trig    (ext_trig),
        .adc_done    (adc_done),
        .ovr_clr     (ovr_clr),
        .req_o       (conv_req),
        .ch_o        (conv_ch),
        .gain_o      (conv_gain),
        .res_valid_o (res_valid),
        .res_ch_o    (res_ch),
        .ovr_o       (ovr_flag)
    );

    adc_seq_pusher u_pusher (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_ch    (res_ch),
        .res_data  (adc_data),
        .fifo_full (fifo_full),
        .ovf_clr   (ovf_clr),
        .push_o    (fifo_push),
        .data_o    (fifo_data),
        .ovf_o     (ovf_flag)
    );
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] GAINS = 32'h1234_DE5F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_scan = 1'b0, cfg_ext_en = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [2:0]  cfg_last = '0;
    logic [31:0] cfg_gain = '0;
    logic [15:0] cfg_div = '0;
    logic        soft_rst = 1'b0, sw_start = 1'b0, ext_trig = 1'b0;
    logic        ovr_clr = 1'b0, ovf_clr = 1'b0;
    logic        conv_req, fifo_push, ovr_flag, ovf_flag;
    logic [2:0]  conv_ch;
    logic [3:0]  conv_gain;
    logic        adc_done = 1'b0, fifo_full = 1'b0;
    logic [15:0] adc_data = '0;
    logic [18:0] fifo_data;

    int n_checks = 0, n_fail = 0, cyc = 0, cfg_cyc = 0;
    bit rsp_en = 1'b0, pend = 1'b0, finished = 1'b0;
    int n_req = 0, n_push = 0, rsp_idx = 0;
    int log_ch[64], log_gain[64], log_cyc[64], log_push[64];

    adc_scan_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_last(cfg_last), .cfg_gain(cfg_gain), .cfg_div(cfg_div),
        .cfg_scan(cfg_scan), .cfg_ext_en(cfg_ext_en), .soft_rst(soft_rst),
        .sw_start(sw_start), .ext_trig(ext_trig), .ovr_clr(ovr_clr),
        .ovf_clr(ovf_clr), .conv_req(conv_req), .conv_ch(conv_ch),
        .conv_gain(conv_gain), .adc_done(adc_done), .adc_data(adc_data),
        .fifo_full(fifo_full), .fifo_push(fifo_push), .fifo_data(fifo_data),
        .ovr_flag(ovr_flag), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Converter model and logger, acting at falling edges
    initial begin
        forever begin
            @(negedge clk);
            adc_done = 1'b0;
            if (pend && rsp_en) begin
                adc_done = 1'b1;
                adc_data = 16'hA000 + 16'(rsp_idx);
                rsp_idx++;
            end
            pend = 1'b0;
            if (conv_req && n_req < 64) begin
                log_ch[n_req]   = int'(conv_ch);
                log_gain[n_req] = int'(conv_gain);
                log_cyc[n_req]  = cyc;
                n_req++;
                pend = 1'b1;
            end
            if (fifo_push && n_push < 64) begin
                log_push[n_push] = int'(fifo_data);
                n_push++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        n_req = 0; n_push = 0; rsp_idx = 0;
    endtask

    task automatic configure(input logic [1:0] m, input logic [2:0] l,
                             input logic [15:0] dv, input logic sc, input logic ex);
        @(negedge clk);
        cfg_mode = m; cfg_last = l; cfg_gain = GAINS; cfg_div = dv;
        cfg_scan = sc; cfg_ext_en = ex; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_cyc = cyc;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
    endtask

    function automatic int gain_of(input int ch);
        return int'((GAINS >> (4*ch)) & 32'hF);
    endfunction

    task automatic t_reset_state();
        chk(conv_req == 1'b0, "R10 reset req", int'(conv_req), 0);
        chk(fifo_push == 1'b0, "R9 reset push", int'(fifo_push), 0);
        chk(ovr_flag == 1'b0 && ovf_flag == 1'b0, "R8 reset flags",
            int'({ovr_flag, ovf_flag}), 0);
        chk(conv_ch == 3'd0, "R10 reset channel", int'(conv_ch), 0);
    endtask

    task automatic t_single_seq();
        rsp_en = 1'b1;
        configure(2'b01, 3'd2, 16'd0, 1'b0, 1'b0);
        clear_log();
        for (int i = 0; i < 4; i++) begin
            pulse_sw();
            wait_cyc(6);
            chk(n_req == i + 1, "R1 one request per start", n_req, i + 1);
            chk(log_ch[i] == i % 3, "R7 pointer advance/wrap", log_ch[i], i % 3);
            chk(log_gain[i] == gain_of(i % 3), "R5 gain per channel", log_gain[i], gain_of(i % 3));
        end
    endtask

    task automatic t_nonseq_forced();
        configure(2'b00, 3'd3, 16'd0, 1'b1, 1'b0);
        clear_log();
        for (int i = 0; i < 3; i++) begin
            pulse_sw();
            wait_cyc(6);
        end
        chk(n_req == 3, "R3 mode 00 forces single", n_req, 3);
        for (int i = 0; i < 3; i++)
            chk(log_ch[i] == 0, "R7 mode 00 stays on channel 0", log_ch[i], 0);
    endtask

    task automatic t_last_zero();
        configure(2'b01, 3'd0, 16'd0, 1'b1, 1'b0);
        clear_log();
        pulse_sw(); wait_cyc(6);
        pulse_sw(); wait_cyc(6);
        chk(n_req == 2, "R3 last index 0 forces single", n_req, 2);
    endtask

    task automatic t_scan_b2b();
        configure(2'b01, 3'd3, 16'd0, 1'b1, 1'b0);
        clear_log();
        pulse_sw();
        wait_cyc(20);
        chk(n_req == 4, "R2 burst length", n_req, 4);
        chk(n_push == 4, "R9 push count", n_push, 4);
        for (int i = 0; i < 4; i++) begin
            chk(log_ch[i] == i, "R2 burst channel order", log_ch[i], i);
            chk(log_push[i] == ((i << 16) | (16'hA000 + i)), "R9 tagged data",
                log_push[i], (i << 16) | (16'hA000 + i));
            if (i > 0)
                chk(log_cyc[i] - log_cyc[i-1] == 2, "R4 back-to-back spacing",
                    log_cyc[i] - log_cyc[i-1], 2);
        end
    endtask

    task automatic t_scan_paced();
        clear_log();
        configure(2'b01, 3'd2, 16'd5, 1'b1, 1'b0);
        clear_log();
        wait_cyc(23);
        chk(n_req >= 4, "R6 periodic starts", n_req, 4);
        chk(log_cyc[0] - cfg_cyc == 5, "R10 first tick after config", log_cyc[0] - cfg_cyc, 5);
        for (int i = 0; i < 4; i++) begin
            chk(log_ch[i] == i % 3, "R2 paced burst order", log_ch[i], i % 3);
            if (i > 0)
                chk(log_cyc[i] - log_cyc[i-1] == 5, "R4 paced spacing",
                    log_cyc[i] - log_cyc[i-1], 5);
        end
        configure(2'b01, 3'd2, 16'd0, 1'b0, 1'b0);
        wait_cyc(4);
    endtask

    task automatic t_start_sources();
        configure(2'b01, 3'd0, 16'd0, 1'b0, 1'b1);
        clear_log();
        pulse_ext(); wait_cyc(8);
        chk(n_req == 0, "R6 ext trigger ignored in software mode", n_req, 0);
        configure(2'b01, 3'd0, 16'd1000, 1'b0, 1'b1);
        clear_log();
        pulse_ext(); wait_cyc(6);
        chk(n_req == 1, "R6 ext trigger starts when timed", n_req, 1);
        configure(2'b01, 3'd0, 16'd0, 1'b0, 1'b0);
    endtask

    task automatic t_overrun_reset();
        rsp_en = 1'b0;
        configure(2'b01, 3'd3, 16'd0, 1'b1, 1'b0);
        clear_log();
        pulse_sw();
        wait_cyc(2);
        chk(ovr_flag == 1'b0, "R8 no overrun yet", int'(ovr_flag), 0);
        pulse_sw();
        wait_cyc(2);
        chk(ovr_flag == 1'b1, "R8 overrun set", int'(ovr_flag), 1);
        chk(n_req == 1, "R8 busy start ignored", n_req, 1);
        wait_cyc(3);
        chk(ovr_flag == 1'b1, "R8 overrun sticky", int'(ovr_flag), 1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk(ovr_flag == 1'b0, "R8 overrun cleared", int'(ovr_flag), 0);
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
        chk(conv_ch == 3'd0 && conv_req == 1'b0, "R10 soft reset idle", int'(conv_ch), 0);
        rsp_en = 1'b1;
        pulse_sw();
        wait_cyc(14);
        chk(n_req == 5, "R10 restart after soft reset", n_req, 5);
        chk(log_ch[1] == 0, "R10 restart at channel 0", log_ch[1], 0);
    endtask

    task automatic t_fifo_full();
        configure(2'b01, 3'd3, 16'd0, 1'b0, 1'b0);
        clear_log();
        fifo_full = 1'b1;
        pulse_sw();
        wait_cyc(6);
        chk(n_push == 0, "R9 push blocked when full", n_push, 0);
        chk(ovf_flag == 1'b1, "R9 overflow set", int'(ovf_flag), 1);
        fifo_full = 1'b0;
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk(ovf_flag == 1'b0, "R9 overflow cleared", int'(ovf_flag), 0);
        pulse_sw();
        wait_cyc(6);
        chk(n_push == 1, "R9 push after clear", n_push, 1);
        chk((log_push[0] >> 16) == 1, "R7 tag after advance", log_push[0] >> 16, 1);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset_state();
        t_single_seq();
        t_nonseq_forced();
        t_last_zero();
        t_scan_b2b();
        t_scan_paced();
        t_start_sources();
        t_overrun_reset();
        t_fifo_full();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule